// File: doc/BRIEF.md
# Four-Port Set/Clear GPIO Controller

This block is a register-mapped general-purpose I/O controller for four pin ports, reached through a simple 32-bit register bus. Ports 0, 1 and 2 are bidirectional and are 8, 24 and 13 pins wide. Port 3 has three kinds of pin: six bidirectional pins, 22 input-only pins and 24 output-only pins. Software never does a read-modify-write to change one pin. It writes a word to a set register to force the selected latches to 1, or to a clear register to force them to 0. State registers read back the latch contents, and input state registers read back the pin levels after synchronization. Port 2 also carries a per-pin selection latch that leaves the block as `p2_mux`. The selection latch has its own set, clear and state registers.

Port 3 packs its bits irregularly. Its bidirectional output levels sit above the output-only pins in the same output registers. Its bidirectional pins take their direction from the upper bits of port 2's direction registers. In its input state word, its bidirectional pins are interleaved with the input-only pins. All external inputs pass through a two-stage synchronizer. The asynchronous active-low reset is released synchronously to the clock.

A write is a one-cycle pulse on `bus_wr` with a byte address and data. A read is a one-cycle pulse on `bus_rd`. The data is returned on `bus_rdata`, with `bus_rvalid` high, in the cycle that follows.

Top module: `gpio_sc_ctrl`

## Requirements
- R1: After reset, every output latch, direction latch and port 2 selection latch is 0. All `*_out`, `*_oe`, `p3_gpo` and `p2_mux` pins are 0, and `bus_rvalid` is 0.
- R2: A write to a set register forces to 1 each latch whose data bit is 1. A write to a clear register forces such latches to 0. Latches whose data bit is 0 are unchanged. For ports 0 and 1, pin n is bit n of every register of the port. The port 0 registers are output set 0x044, output clear 0x048, output state 0x04C and input state 0x040. The port 1 registers are the same layout plus 0x020.
- R3: A direction latch at 1 makes the pin an output (`oe` high), and at 0 an input. The port 0 direction registers are set 0x050, clear 0x054 and state 0x058. Port 1 uses 0x070, 0x074 and 0x078.
- R4: Port 2 pin n is bit n of its registers. Its direction registers are set 0x010, clear 0x014 and state 0x018. Its output registers are set 0x020 and clear 0x024. Its input state is at 0x01C. Its selection latch registers are set 0x028, clear 0x02C and state 0x030, and the latch drives `p2_mux`.
- R5: In port 3's output set 0x004 and output clear 0x008, output-only pin k is bit k (k = 0 to 23) and bidirectional pin k is bit 25+k (k = 0 to 5). Output state 0x00C reads back both groups at the same positions.
- R6: The direction of port 3 bidirectional pin k is bit 25+k of port 2's direction registers 0x010, 0x014 and 0x018. No port 3 register controls it.
- R7: Port 3 input state 0x000 places the bits as follows. Input-only pins 0 to 9 are at bits 0 to 9, pins 10 to 18 at bits 15 to 23, and pins 19 to 21 at bits 25 to 27. Bidirectional pins 0 to 4 are at bits 10 to 14, and bidirectional pin 5 is at bit 24.
- R8: An input pin change is absent from reads issued in the cycle of the change and the next cycle. It is present in reads issued two cycles after the change.
- R9: Reads of write-only, unmapped or unaligned addresses return 0, and unused bit positions read 0. Writes to state registers, input registers or unmapped addresses change nothing.
- R10: `bus_rvalid` is high exactly in the cycle after a `bus_rd` pulse, and `bus_rdata` holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| p0_in | input | 8 | Port 0 pin levels |
| p0_out | output | 8 | Port 0 output levels |
| p0_oe | output | 8 | Port 0 output enables |
| p1_in | input | 24 | Port 1 pin levels |
| p1_out | output | 24 | Port 1 output levels |
| p1_oe | output | 24 | Port 1 output enables |
| p2_in | input | 13 | Port 2 pin levels |
| p2_out | output | 13 | Port 2 output levels |
| p2_oe | output | 13 | Port 2 output enables |
| p2_mux | output | 13 | Port 2 pin function select |
| p3_io_in | input | 6 | Port 3 bidirectional pin levels |
| p3_io_out | output | 6 | Port 3 bidirectional output levels |
| p3_io_oe | output | 6 | Port 3 bidirectional output enables |
| p3_gpi | input | 22 | Port 3 input-only pins |
| p3_gpo | output | 24 | Port 3 output-only pins |

## Verification
Some behaviours are checked by assertions on every cycle:
- Each set/clear latch slice checks that a set leaves every written one at 1, that a clear leaves it at 0, and that no other cycle changes the latch.
- The synchronizer stages are checked to follow their source one cycle late.
- The bus checks cover the read-valid timing, read data holding while idle, zero data from unmapped reads, and state-register writes leaving the pins untouched.

Other behaviours only the bench scenarios can show:
- the irregular port 3 bit positions in the input and output words;
- the borrowing of port 2's direction bits;
- the exact two-cycle input latency;
- the specific latch values after mixed set and clear sequences.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

  localparam int BUS_W    = 32;
  localparam int ADDR_W   = 8;
  localparam int P0_W     = 8;
  localparam int P1_W     = 24;
  localparam int P2_W     = 13;
  localparam int P3_IO_W  = 6;
  localparam int P3_GPO_W = 24;
  localparam int P3_GPI_W = 22;

  // port 3 bidirectional group position in output and direction words
  localparam int P3_IO_LSB   = 25;
  localparam int P2_DIR_GAP  = P3_IO_LSB - P2_W;
  localparam int P3_OUT_GAP  = P3_IO_LSB - P3_GPO_W;
  localparam int P3_TOP_GAP  = BUS_W - P3_IO_LSB - P3_IO_W;

  // port 3 input word layout
  localparam int GPI_LO_N      = 10;
  localparam int GPI_MID_N     = 9;
  localparam int GPI_MID_SHIFT = 5;
  localparam int GPI_HI_SHIFT  = 6;
  localparam int IO_IN_LSB     = 10;
  localparam int IO_IN_LOW_N   = 5;
  localparam int IO5_IN_BIT    = 24;

  localparam int SYNC_W = P0_W + P1_W + P2_W + P3_IO_W + P3_GPI_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BUS_W-1:0]  word_t;

  localparam addr_t A_P3_IN     = 8'h00;
  localparam addr_t A_P3_OSET   = 8'h04;
  localparam addr_t A_P3_OCLR   = 8'h08;
  localparam addr_t A_P3_OSTATE = 8'h0C;
  localparam addr_t A_P2_DSET   = 8'h10;
  localparam addr_t A_P2_DCLR   = 8'h14;
  localparam addr_t A_P2_DSTATE = 8'h18;
  localparam addr_t A_P2_IN     = 8'h1C;
  localparam addr_t A_P2_OSET   = 8'h20;
  localparam addr_t A_P2_OCLR   = 8'h24;
  localparam addr_t A_P2_MSET   = 8'h28;
  localparam addr_t A_P2_MCLR   = 8'h2C;
  localparam addr_t A_P2_MSTATE = 8'h30;
  localparam addr_t A_P0_BASE   = 8'h40;
  localparam addr_t A_P1_BASE   = 8'h60;
  // offsets inside a port 0 / port 1 window
  localparam addr_t R_IN     = 8'h00;
  localparam addr_t R_OSET   = 8'h04;
  localparam addr_t R_OCLR   = 8'h08;
  localparam addr_t R_OSTATE = 8'h0C;
  localparam addr_t R_DSET   = 8'h10;
  localparam addr_t R_DCLR   = 8'h14;
  localparam addr_t R_DSTATE = 8'h18;

  function automatic word_t p3_in_word(logic [P3_GPI_W-1:0] gpi,
                                       logic [P3_IO_W-1:0]  io);
    word_t w;
    w = '0;
    for (int i = 0; i < P3_GPI_W; i++) begin
      if (i < GPI_LO_N)                  w[i]                 = gpi[i];
      else if (i < GPI_LO_N + GPI_MID_N) w[i + GPI_MID_SHIFT] = gpi[i];
      else                               w[i + GPI_HI_SHIFT]  = gpi[i];
    end
    for (int k = 0; k < IO_IN_LOW_N; k++) w[IO_IN_LSB + k] = io[k];
    w[IO5_IN_BIT] = io[P3_IO_W-1];
    return w;
  endfunction

  function automatic logic is_readable(addr_t a);
    return (a == A_P3_IN)   || (a == A_P3_OSTATE) || (a == A_P2_DSTATE) ||
           (a == A_P2_IN)   || (a == A_P2_MSTATE) ||
           (a == A_P0_BASE + R_IN) || (a == A_P0_BASE + R_OSTATE) ||
           (a == A_P0_BASE + R_DSTATE) ||
           (a == A_P1_BASE + R_IN) || (a == A_P1_BASE + R_OSTATE) ||
           (a == A_P1_BASE + R_DSTATE);
  endfunction

endpackage

// File: rtl/gpio_sc_rst_sync.sv
module gpio_sc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_sc_in_sync.sv
module gpio_sc_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = din;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign dout = stg_q[STAGES-1];

  for (genvar i = 0; i < STAGES; i++) begin : g_chk
    if (i == 0) begin : g_first
      // R8: first stage captures the pin one cycle later
      p_first_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stg_q[0] == $past(din))
        else $error("first sync stage lost the pin value");
    end else begin : g_next
      // R8: each later stage trails the one before by a cycle
      p_next_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stg_q[i] == $past(stg_q[i-1]))
        else $error("sync stage does not trail its source");
    end
  end
endmodule

// File: rtl/gpio_sc_setclr.sv
module gpio_sc_setclr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic [W-1:0] set_mask;
  logic [W-1:0] clr_mask;
  logic         upd_en;

  always_comb begin
    set_mask = set_en ? wdata : '0;
    clr_mask = clr_en ? wdata : '0;
    upd_en   = set_en | clr_en;
    q_d      = (q | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (upd_en) q <= q_d;
  end

  // R2: every bit written as one through a set ends at 1
  p_set_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((q & $past(wdata)) == $past(wdata)))
    else $error("set left a selected latch low");

  // R2: every bit written as one through a clear ends at 0
  p_clr_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((q & $past(wdata)) == '0))
    else $error("clear left a selected latch high");

  // R2: bits written as zero keep their value
  p_zero_bits_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en || clr_en) |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))))
    else $error("unselected latch changed");

  // R9: no strobe, no change
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en || clr_en) |=> $stable(q))
    else $error("latch changed without a strobe");
endmodule

// File: rtl/gpio_sc_rd_mux.sv
module gpio_sc_rd_mux
  import gpio_sc_pkg::*;
(
  input  addr_t                 addr,
  input  logic [P0_W-1:0]       p0_in_s,
  input  logic [P0_W-1:0]       p0_out_q,
  input  logic [P0_W-1:0]       p0_dir_q,
  input  logic [P1_W-1:0]       p1_in_s,
  input  logic [P1_W-1:0]       p1_out_q,
  input  logic [P1_W-1:0]       p1_dir_q,
  input  logic [P2_W-1:0]       p2_in_s,
  input  logic [P2_W-1:0]       p2_dir_q,
  input  logic [P2_W-1:0]       p2_mux_q,
  input  logic [P3_IO_W-1:0]    p3_dir_q,
  input  logic [P3_IO_W-1:0]    p3_io_in_s,
  input  logic [P3_IO_W-1:0]    p3_io_out_q,
  input  logic [P3_GPI_W-1:0]   p3_gpi_s,
  input  logic [P3_GPO_W-1:0]   p3_gpo_q,
  output word_t                 rd_word
);
  always_comb begin
    rd_word = '0;
    case (addr)
      A_P3_IN:     rd_word = p3_in_word(p3_gpi_s, p3_io_in_s);
      A_P3_OSTATE: rd_word = {{P3_TOP_GAP{1'b0}}, p3_io_out_q,
                              {P3_OUT_GAP{1'b0}}, p3_gpo_q};
      A_P2_DSTATE: rd_word = {{P3_TOP_GAP{1'b0}}, p3_dir_q,
                              {P2_DIR_GAP{1'b0}}, p2_dir_q};
      A_P2_IN:     rd_word = BUS_W'(p2_in_s);
      A_P2_MSTATE: rd_word = BUS_W'(p2_mux_q);
      A_P0_BASE + R_IN:     rd_word = BUS_W'(p0_in_s);
      A_P0_BASE + R_OSTATE: rd_word = BUS_W'(p0_out_q);
      A_P0_BASE + R_DSTATE: rd_word = BUS_W'(p0_dir_q);
      A_P1_BASE + R_IN:     rd_word = BUS_W'(p1_in_s);
      A_P1_BASE + R_OSTATE: rd_word = BUS_W'(p1_out_q);
      A_P1_BASE + R_DSTATE: rd_word = BUS_W'(p1_dir_q);
      default:     rd_word = '0;
    endcase
  end
endmodule

// File: rtl/gpio_sc_ctrl.sv
module gpio_sc_ctrl
  import gpio_sc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  output logic                bus_rvalid,
  input  logic [P0_W-1:0]     p0_in,
  output logic [P0_W-1:0]     p0_out,
  output logic [P0_W-1:0]     p0_oe,
  input  logic [P1_W-1:0]     p1_in,
  output logic [P1_W-1:0]     p1_out,
  output logic [P1_W-1:0]     p1_oe,
  input  logic [P2_W-1:0]     p2_in,
  output logic [P2_W-1:0]     p2_out,
  output logic [P2_W-1:0]     p2_oe,
  output logic [P2_W-1:0]     p2_mux,
  input  logic [P3_IO_W-1:0]  p3_io_in,
  output logic [P3_IO_W-1:0]  p3_io_out,
  output logic [P3_IO_W-1:0]  p3_io_oe,
  input  logic [P3_GPI_W-1:0] p3_gpi,
  output logic [P3_GPO_W-1:0] p3_gpo
);
  localparam int IO_MSB = P3_IO_LSB + P3_IO_W - 1;

  logic rst_n_s;

  gpio_sc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  // ---------------- input synchronizer ----------------
  logic [SYNC_W-1:0]   raw_in;
  logic [SYNC_W-1:0]   sync_in;
  logic [P0_W-1:0]     p0_in_s;
  logic [P1_W-1:0]     p1_in_s;
  logic [P2_W-1:0]     p2_in_s;
  logic [P3_IO_W-1:0]  p3_io_in_s;
  logic [P3_GPI_W-1:0] p3_gpi_s;

  assign raw_in = {p3_gpi, p3_io_in, p2_in, p1_in, p0_in};

  gpio_sc_in_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .din   (raw_in),
    .dout  (sync_in)
  );

  assign {p3_gpi_s, p3_io_in_s, p2_in_s, p1_in_s, p0_in_s} = sync_in;

  // ---------------- write decode ----------------
  logic wr_p0_os, wr_p0_oc, wr_p0_ds, wr_p0_dc;
  logic wr_p1_os, wr_p1_oc, wr_p1_ds, wr_p1_dc;
  logic wr_p2_os, wr_p2_oc, wr_p2_ds, wr_p2_dc, wr_p2_ms, wr_p2_mc;
  logic wr_p3_os, wr_p3_oc;

  always_comb begin
    wr_p0_os = bus_wr && (bus_addr == A_P0_BASE + R_OSET);
    wr_p0_oc = bus_wr && (bus_addr == A_P0_BASE + R_OCLR);
    wr_p0_ds = bus_wr && (bus_addr == A_P0_BASE + R_DSET);
    wr_p0_dc = bus_wr && (bus_addr == A_P0_BASE + R_DCLR);
    wr_p1_os = bus_wr && (bus_addr == A_P1_BASE + R_OSET);
    wr_p1_oc = bus_wr && (bus_addr == A_P1_BASE + R_OCLR);
    wr_p1_ds = bus_wr && (bus_addr == A_P1_BASE + R_DSET);
    wr_p1_dc = bus_wr && (bus_addr == A_P1_BASE + R_DCLR);
    wr_p2_os = bus_wr && (bus_addr == A_P2_OSET);
    wr_p2_oc = bus_wr && (bus_addr == A_P2_OCLR);
    wr_p2_ds = bus_wr && (bus_addr == A_P2_DSET);
    wr_p2_dc = bus_wr && (bus_addr == A_P2_DCLR);
    wr_p2_ms = bus_wr && (bus_addr == A_P2_MSET);
    wr_p2_mc = bus_wr && (bus_addr == A_P2_MCLR);
    wr_p3_os = bus_wr && (bus_addr == A_P3_OSET);
    wr_p3_oc = bus_wr && (bus_addr == A_P3_OCLR);
  end

  // bits 24 and 31 of the write word select no latch
  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata[BUS_W-1], bus_wdata[P3_IO_LSB-1]};

  // ---------------- latch slices ----------------
  gpio_sc_setclr #(.W(P0_W)) u_p0_out (
    .clk(clk), .rst_n(rst_n_s), .set_en(wr_p0_os), .clr_en(wr_p0_oc),
    .wdata(bus_wdata[P0_W-1:0]), .q(p0_out));
  gpio_sc_setclr #(.W(P0_W)) u_p0_dir (
    .clk(clk), .rst_n(rst_n_s), .set_en(wr_p0_ds), .clr_en(wr_p0_dc),
    .wdata(bus_wdata[P0_W-1:0]), .q(p0_oe));

  gpio_sc_setclr #(.W(P1_W)) u_p1_out (
    .clk(clk), .rst_n(rst_n_s), .set_en(wr_p1_os), .clr_en(wr_p1_oc),
    .wdata(bus_wdata[P1_W-1:0]), .q(p1_out));
  gpio_sc_setclr #(.W(P1_W)) u_p1_dir (
    .clk(clk), .rst_n(rst_n_s), .set_en(wr_p1_ds), .clr_en(wr_p1_dc),
    .wdata(bus_wdata[P1_W-1:0]), .q(p1_oe));

  gpio_sc_setclr #(.W(P2_W)) u_p2_out (
    .clk(clk), .rst_n(rst_n_s), .set_en(wr_p2_os), .clr_en(wr_p2_oc),
    .wdata(bus_wdata[P2_W-1:0]), .q(p2_out));
  gpio_sc_setclr #(.W(P2_W)) u_p2_dir (
    .clk(clk), .rst_n(rst_n_s), .set_en(wr_p2_ds), .clr_en(wr_p2_dc),
    .wdata(bus_wdata[P2_W-1:0]), .q(p2_oe));
  gpio_sc_setclr #(.W(P2_W)) u_p2_mux (
    .clk(clk), .rst_n(rst_n_s), .set_en(wr_p2_ms), .clr_en(wr_p2_mc),
    .wdata(bus_wdata[P2_W-1:0]), .q(p2_mux));

  // port 3 bidirectional direction lives in port 2's direction registers
  gpio_sc_setclr #(.W(P3_IO_W)) u_p3_dir (
    .clk(clk), .rst_n(rst_n_s), .set_en(wr_p2_ds), .clr_en(wr_p2_dc),
    .wdata(bus_wdata[IO_MSB:P3_IO_LSB]), .q(p3_io_oe));
  gpio_sc_setclr #(.W(P3_IO_W)) u_p3_io_out (
    .clk(clk), .rst_n(rst_n_s), .set_en(wr_p3_os), .clr_en(wr_p3_oc),
    .wdata(bus_wdata[IO_MSB:P3_IO_LSB]), .q(p3_io_out));
  gpio_sc_setclr #(.W(P3_GPO_W)) u_p3_gpo (
    .clk(clk), .rst_n(rst_n_s), .set_en(wr_p3_os), .clr_en(wr_p3_oc),
    .wdata(bus_wdata[P3_GPO_W-1:0]), .q(p3_gpo));

  // ---------------- read path ----------------
  word_t rd_word;
  word_t rdata_d;
  logic  rvalid_d;

  gpio_sc_rd_mux u_rd (
    .addr        (bus_addr),
    .p0_in_s     (p0_in_s),
    .p0_out_q    (p0_out),
    .p0_dir_q    (p0_oe),
    .p1_in_s     (p1_in_s),
    .p1_out_q    (p1_out),
    .p1_dir_q    (p1_oe),
    .p2_in_s     (p2_in_s),
    .p2_dir_q    (p2_oe),
    .p2_mux_q    (p2_mux),
    .p3_dir_q    (p3_io_oe),
    .p3_io_in_s  (p3_io_in_s),
    .p3_io_out_q (p3_io_out),
    .p3_gpi_s    (p3_gpi_s),
    .p3_gpo_q    (p3_gpo),
    .rd_word     (rd_word)
  );

  always_comb begin
    rdata_d  = rd_word;
    rvalid_d = bus_rd;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) bus_rvalid <= 1'b0;
    else          bus_rvalid <= rvalid_d;
  end

  // ---------------- assertions ----------------
  // R10: valid follows a read strobe by one cycle
  p_rvalid_after_rd_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_rd |=> bus_rvalid)
    else $error("read strobe not followed by valid");

  // R10: no valid without a strobe, and data held
  p_rvalid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bus_rd |=> (!bus_rvalid && $stable(bus_rdata)))
    else $error("valid or data moved without a read");

  // R9: unmapped or write-only addresses read as zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_rd && !is_readable(bus_addr)) |=> (bus_rdata == '0))
    else $error("unmapped read returned nonzero data");

  // R9: writes to state registers leave the pins untouched
  p_state_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && is_readable(bus_addr)) |=>
      $stable({p0_out, p0_oe, p1_out, p1_oe, p2_out, p2_oe, p2_mux,
               p3_io_out, p3_io_oe, p3_gpo}))
    else $error("write to a state register changed a latch");
endmodule

// File: tb/gpio_sc_ctrl_test.sv
module gpio_sc_ctrl_test;
  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  p0_in, p0_out, p0_oe;
  logic [23:0] p1_in, p1_out, p1_oe;
  logic [12:0] p2_in, p2_out, p2_oe, p2_mux;
  logic [5:0]  p3_io_in, p3_io_out, p3_io_oe;
  logic [21:0] p3_gpi;
  logic [23:0] p3_gpo;

  int n_chk = 0;
  int n_err = 0;
  logic mon_on = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  gpio_sc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid),
    .p0_in(p0_in), .p0_out(p0_out), .p0_oe(p0_oe),
    .p1_in(p1_in), .p1_out(p1_out), .p1_oe(p1_oe),
    .p2_in(p2_in), .p2_out(p2_out), .p2_oe(p2_oe), .p2_mux(p2_mux),
    .p3_io_in(p3_io_in), .p3_io_out(p3_io_out), .p3_io_oe(p3_io_oe),
    .p3_gpi(p3_gpi), .p3_gpo(p3_gpo)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: called just after a falling edge, returns one cycle later
  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    bus_addr = a;
    bus_rd   = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: pops the scoreboard whenever read data is presented
  always @(negedge clk) begin
    if (mon_on && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_err++;
        $display("FAIL R10 unexpected rvalid act=%h exp=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, bus_rdata, e);
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    p0_in = '0; p1_in = '0; p2_in = '0; p3_io_in = '0; p3_gpi = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    mon_on = 1'b1;

    // R1 reset state at the pins
    chk("R1 p0_out", 32'(p0_out), 0);
    chk("R1 p1_oe", 32'(p1_oe), 0);
    chk("R1 p2_mux", 32'(p2_mux), 0);
    chk("R1 p3 outs", {p3_io_out, p3_io_oe, p3_gpo}, 0);
    chk("R1 rvalid", 32'(bus_rvalid), 0);
    rd(8'h4C, 0, "R1 p0 out state");
    rd(8'h78, 0, "R1 p1 dir state");
    rd(8'h18, 0, "R1 p2 dir state");
    rd(8'h30, 0, "R1 p2 sel state");
    rd(8'h0C, 0, "R1 p3 out state");
    idle(1);
    chk("R10 rvalid low when idle", 32'(bus_rvalid), 0);

    // R2 set/clear on port 0
    wr(8'h44, 32'h0000_00A5);
    chk("R2 p0 set", 32'(p0_out), 32'hA5);
    wr(8'h48, 32'h0000_0021);
    chk("R2 p0 clear", 32'(p0_out), 32'h84);
    wr(8'h44, 32'hFFFF_FF00);
    chk("R2 zero bits keep", 32'(p0_out), 32'h84);
    rd(8'h4C, 32'h84, "R2 p0 out state");

    // R3 direction on port 0
    wr(8'h50, 32'h0F);
    chk("R3 p0 oe set", 32'(p0_oe), 32'h0F);
    wr(8'h54, 32'h03);
    chk("R3 p0 oe clear", 32'(p0_oe), 32'h0C);
    rd(8'h58, 32'h0C, "R3 p0 dir state");

    // R2/R3 port 1
    wr(8'h64, 32'h00AB_CDEF);
    wr(8'h68, 32'h0000_000F);
    chk("R2 p1 out", 32'(p1_out), 32'hABCDE0);
    wr(8'h70, 32'h0080_0001);
    chk("R3 p1 oe", 32'(p1_oe), 32'h800001);
    rd(8'h6C, 32'hABCDE0, "R2 p1 out state");
    rd(8'h78, 32'h800001, "R3 p1 dir state");
    p1_in = 24'h123456;
    idle(3);
    rd(8'h60, 32'h123456, "R2 p1 input state");

    // R4 port 2
    wr(8'h20, 32'h1FFF);
    wr(8'h24, 32'h1000);
    chk("R4 p2 out", 32'(p2_out), 32'h0FFF);
    wr(8'h28, 32'h0155);
    wr(8'h2C, 32'h0005);
    chk("R4 p2 sel pins", 32'(p2_mux), 32'h0150);
    rd(8'h30, 32'h0150, "R4 p2 sel state");
    p2_in = 13'h1ABC;
    idle(3);
    rd(8'h1C, 32'h1ABC, "R4 p2 input state");

    // R6 port 3 direction through port 2 direction registers
    wr(8'h10, 32'h7E00_1005);
    chk("R4 p2 oe", 32'(p2_oe), 32'h1005);
    chk("R6 p3 oe set", 32'(p3_io_oe), 32'h3F);
    wr(8'h14, 32'h0A00_0000);
    chk("R6 p3 oe clear", 32'(p3_io_oe), 32'h3A);
    chk("R6 p2 oe untouched", 32'(p2_oe), 32'h1005);
    rd(8'h18, 32'h7400_1005, "R6 shared dir state");

    // R5 port 3 outputs
    wr(8'h04, 32'h40FF_FFFF);
    chk("R5 gpo set", 32'(p3_gpo), 32'hFFFFFF);
    chk("R5 io out set", 32'(p3_io_out), 32'h20);
    wr(8'h08, 32'h0280_0001);
    chk("R5 gpo clear", 32'(p3_gpo), 32'h7FFFFE);
    wr(8'h04, 32'h0600_0000);
    chk("R5 io out bits 25,26", 32'(p3_io_out), 32'h23);
    rd(8'h0C, 32'h467F_FFFE, "R5 p3 out state");

    // R7 port 3 input word
    p3_io_in = 6'h21;
    p3_gpi   = 22'h3F_FFFF;
    idle(3);
    rd(8'h00, 32'h0FFF_87FF, "R7 all inputs high");
    p3_io_in = 6'h1E;
    p3_gpi   = 22'h08_0400;
    idle(3);
    rd(8'h00, 32'h0200_F800, "R7 sparse pattern");

    // R8 two-cycle synchronizer latency
    p0_in = 8'h5A;
    rd(8'h40, 32'h00, "R8 same cycle");
    rd(8'h40, 32'h00, "R8 one cycle later");
    rd(8'h40, 32'h5A, "R8 two cycles later");

    // R9 ignored writes and zero reads
    wr(8'h4C, 32'hFF);
    chk("R9 out state write ignored", 32'(p0_out), 32'h84);
    wr(8'h58, 32'hFF);
    chk("R9 dir state write ignored", 32'(p0_oe), 32'h0C);
    wr(8'h3C, 32'hFFFF_FFFF);
    chk("R9 unmapped write ignored", {p3_gpo, p0_out}, {24'h7FFFFE, 8'h84});
    wr(8'h45, 32'hFF);
    chk("R9 unaligned write ignored", 32'(p0_out), 32'h84);
    rd(8'h44, 0, "R9 write-only reads zero");
    rd(8'h34, 0, "R9 unmapped reads zero");
    rd(8'h41, 0, "R9 unaligned reads zero");
    rd(8'h58, 32'h0C, "R9 dir state after ignored writes");
    idle(1);
    rd(8'h4C, 32'h84, "R10 back-to-back read 1");
    rd(8'h78, 32'h800001, "R10 back-to-back read 2");
    idle(3);
    chk("R10 scoreboard drained", exp_q.size(), 0);
    chk("R10 rvalid low at end", 32'(bus_rvalid), 0);
    finish_run();
  end
endmodule